// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a translation miss by reading descriptors from a two-level translation table held in memory. A miss request brings a virtual address. The walker reads a first-level descriptor through a single-outstanding 32-bit read port. A first-level descriptor can map a 1 MB or 16 MB region directly, or it can point to a second-level table. In the second case the walker reads one more descriptor, which maps a 4 KB or 64 KB page. The walker then returns one result: either a physical page base with a size code and page attributes, or a fault that carries the virtual address.

The attributes are endianness, element size and a mixed-size flag. They sit at different bit positions in first-level and second-level descriptors, and the walker moves them onto one set of result pins. A control input turns walking off. A miss that arrives while walking is off ends as a fault at once, and the walker makes no memory read for it. The TLB that the result refills is not part of this block.

Top module: `pgwalk_top`

## Requirements
- R1: A write to the table base clears bits 6:0 of the written value. Every first-level fetch address is built from the base with those bits at zero.
- R2: A miss is accepted when `missValid` and `missReady` are both high and walking is enabled. In the next cycle `memReq` pulses with `memAddr` = table base + VA[31:20]×4.
- R3: A first-level descriptor with bits 1:0 = 2 and bit 18 clear gives a 1 MB result. Its size code is 0 and its base is bits 31:20 of the descriptor, with the lower bits at zero.
- R4: A first-level descriptor with bits 1:0 = 2 and bit 18 set gives a 16 MB result. Its size code is 3 and its base is bits 31:24 of the descriptor, with the lower bits at zero.
- R5: First-level block attributes come from descriptor bits as follows: endianness from bit 15, mixed-size from bit 17, element size from bits 11:10.
- R6: A first-level descriptor with bits 1:0 = 1 starts a second-level fetch. It is issued the cycle after that response, at {descriptor[31:10], VA[19:12], 2'b00}.
- R7: A second-level descriptor with bits 1:0 = 2 gives a 4 KB page with size code 2 and base bits 31:12. One with bits 1:0 = 1 gives a 64 KB page with size code 1 and base bits 31:16.
- R8: Second-level attributes come from descriptor bits as follows: endianness from bit 9, mixed-size from bit 11, element size from bits 5:4.
- R9: A descriptor type of 0 (an all-zero descriptor included) or 3, at either level, gives a fault. The fault has `resAddr` equal to the miss VA and is not followed by any further fetch.
- R10: A miss accepted while `walkEn` is low gives a fault in the next cycle, with `resAddr` equal to the VA, and no `memReq`.
- R11: `missReady` is high only while no walk is in progress. Each accepted miss produces exactly one single-cycle `resValid`, one cycle after its final memory response.
- R12: A `memRspValid` that arrives while no read is outstanding is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tblBaseWe | input | 1 | Write strobe for the table base |
| tblBaseIn | input | 32 | Table base value to write |
| walkEn | input | 1 | Enables table walking |
| missValid | input | 1 | Miss request valid |
| missReady | output | 1 | Walker idle and able to take a miss |
| missVa | input | 32 | Virtual address of the miss |
| memReq | output | 1 | One-cycle memory read request |
| memAddr | output | 32 | Descriptor address of the read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data (descriptor) |
| resValid | output | 1 | One-cycle result strobe |
| resFault | output | 1 | Result is a translation fault |
| resSize | output | 2 | Size code: 0 = 1 MB, 1 = 64 KB, 2 = 4 KB, 3 = 16 MB |
| resAddr | output | 32 | Physical page base, or the faulting VA |
| resEndian | output | 1 | Endianness attribute |
| resElemSize | output | 2 | Element size attribute |
| resMixed | output | 1 | Mixed-size attribute |

## Verification
Each result has a fixed due cycle:
- The first-level read is due one cycle after the miss is accepted.
- A second-level read is due one cycle after the pointer descriptor returns.
- A walk-off fault is due one cycle after acceptance.
- Every other result is due one cycle after the last memory response.

The driver stamps each expected item with its due cycle, taken from a free-running cycle counter, at the moment it drives the stimulus that causes the result. The monitor samples on falling edges and compares both the fields and the cycle in which `resValid` appeared. Fetch addresses and the absence of a fetch are checked on the falling edge after the edge that registers them.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  localparam int VA_W       = 32;
  localparam int L1_IDX_W   = 12;
  localparam int L2_IDX_W   = 8;
  localparam int PAGE_SHIFT = 12;
  localparam int TBL_ALIGN  = 7;
  localparam int WORD_SHIFT = 2;
  localparam int COARSE_LSB = L2_IDX_W + WORD_SHIFT;

  typedef enum logic [1:0] {
    SZ_SECTION = 2'd0,
    SZ_LARGE   = 2'd1,
    SZ_SMALL   = 2'd2,
    SZ_SUPER   = 2'd3
  } pageSize_e;

  typedef enum logic [1:0] {
    DK_FAULT = 2'd0,
    DK_TABLE = 2'd1,
    DK_PAGE  = 2'd2
  } descKind_e;

  typedef struct packed {
    logic       endian;
    logic [1:0] elemSize;
    logic       mixed;
  } pageAttr_t;

  typedef struct packed {
    logic acceptMiss;
    logic walkOff;
    logic startL1;
    logic startL2;
    logic resolveL1;
    logic resolveL2;
  } walkStrobe_t;

endpackage

// File: rtl/pgwalk_desc.sv
module pgwalk_desc
  import pgwalk_pkg::*;
#(
  parameter int LEVEL = 1
) (
  input  logic [VA_W-1:0] desc,
  output descKind_e       kind,
  output pageSize_e       size,
  output logic [VA_W-1:0] base,
  output pageAttr_t       attr
);

  generate
    if (LEVEL == 1) begin : g_level1
      // first level: block mappings or a pointer to a coarse table
      always_comb begin
        kind = DK_FAULT;
        size = SZ_SECTION;
        base = '0;
        attr = '{endian: desc[15], elemSize: desc[11:10], mixed: desc[17]};
        unique case (desc[1:0])
          2'b01: begin
            kind = DK_TABLE;
            base = {desc[VA_W-1:COARSE_LSB], {COARSE_LSB{1'b0}}};
          end
          2'b10: begin
            kind = DK_PAGE;
            if (desc[18]) begin
              size = SZ_SUPER;
              base = {desc[31:24], 24'b0};
            end else begin
              size = SZ_SECTION;
              base = {desc[31:20], 20'b0};
            end
          end
          default: ;
        endcase
      end
    end else begin : g_level2
      // second level: small and large pages only
      always_comb begin
        kind = DK_FAULT;
        size = SZ_SMALL;
        base = '0;
        attr = '{endian: desc[9], elemSize: desc[5:4], mixed: desc[11]};
        unique case (desc[1:0])
          2'b10: begin
            kind = DK_PAGE;
            size = SZ_SMALL;
            base = {desc[31:12], 12'b0};
          end
          2'b01: begin
            kind = DK_PAGE;
            size = SZ_LARGE;
            base = {desc[31:16], 16'b0};
          end
          default: ;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        missValid,
  input  logic        walkEn,
  input  logic        memRspValid,
  input  descKind_e   kindL1,
  output logic        missReady,
  output walkStrobe_t strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT1, ST_WAIT2} walkState_e;

  walkState_e state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (missValid) begin
          strb.acceptMiss = 1'b1;
          if (walkEn) begin
            strb.startL1 = 1'b1;
            nextState    = ST_WAIT1;
          end else begin
            strb.walkOff = 1'b1;
          end
        end
      end
      ST_WAIT1: begin
        if (memRspValid) begin
          if (kindL1 == DK_TABLE) begin
            strb.startL2 = 1'b1;
            nextState    = ST_WAIT2;
          end else begin
            strb.resolveL1 = 1'b1;
            nextState      = ST_IDLE;
          end
        end
      end
      ST_WAIT2: begin
        if (memRspValid) begin
          strb.resolveL2 = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign missReady = (state == ST_IDLE);

endmodule

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tblBaseWe,
  input  logic [VA_W-1:0] tblBaseIn,
  input  logic [VA_W-1:0] missVa,
  input  logic [VA_W-1:0] memRspData,
  input  walkStrobe_t     strb,
  output descKind_e       kindL1,
  output logic            memReq,
  output logic [VA_W-1:0] memAddr,
  output logic            resValid,
  output logic            resFault,
  output pageSize_e       resSize,
  output logic [VA_W-1:0] resAddr,
  output pageAttr_t       resAttr
);

  localparam int L1_PAD = VA_W - L1_IDX_W - WORD_SHIFT;

  logic [VA_W-1:0] tblBase;
  logic [VA_W-1:0] vaReg;

  pageSize_e       l1Size, l2Size, selSize;
  logic [VA_W-1:0] l1Base, l2Base, selBase;
  pageAttr_t       l1Attr, l2Attr, selAttr;
  descKind_e       l2Kind, selKind;

  pgwalk_desc #(.LEVEL(1)) u_l1dec (
    .desc(memRspData), .kind(kindL1), .size(l1Size), .base(l1Base), .attr(l1Attr)
  );

  pgwalk_desc #(.LEVEL(2)) u_l2dec (
    .desc(memRspData), .kind(l2Kind), .size(l2Size), .base(l2Base), .attr(l2Attr)
  );

  always_comb begin
    selKind = strb.resolveL2 ? l2Kind : kindL1;
    selSize = strb.resolveL2 ? l2Size : l1Size;
    selBase = strb.resolveL2 ? l2Base : l1Base;
    selAttr = strb.resolveL2 ? l2Attr : l1Attr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tblBase  <= '0;
      vaReg    <= '0;
      memReq   <= 1'b0;
      memAddr  <= '0;
      resValid <= 1'b0;
      resFault <= 1'b0;
      resSize  <= SZ_SECTION;
      resAddr  <= '0;
      resAttr  <= '0;
    end else begin
      if (tblBaseWe) tblBase <= {tblBaseIn[VA_W-1:TBL_ALIGN], {TBL_ALIGN{1'b0}}};
      if (strb.acceptMiss) vaReg <= missVa;

      memReq <= strb.startL1 | strb.startL2;
      if (strb.startL1)
        memAddr <= tblBase + {{L1_PAD{1'b0}}, missVa[VA_W-1 -: L1_IDX_W], {WORD_SHIFT{1'b0}}};
      else if (strb.startL2)
        memAddr <= {l1Base[VA_W-1:COARSE_LSB],
                    vaReg[PAGE_SHIFT+L2_IDX_W-1 -: L2_IDX_W], {WORD_SHIFT{1'b0}}};

      resValid <= strb.walkOff | strb.resolveL1 | strb.resolveL2;
      if (strb.walkOff) begin
        resFault <= 1'b1;
        resAddr  <= missVa;
        resSize  <= SZ_SECTION;
        resAttr  <= '0;
      end else if (strb.resolveL1 | strb.resolveL2) begin
        if (selKind == DK_PAGE) begin
          resFault <= 1'b0;
          resAddr  <= selBase;
          resSize  <= selSize;
          resAttr  <= selAttr;
        end else begin
          resFault <= 1'b1;
          resAddr  <= vaReg;
          resSize  <= SZ_SECTION;
          resAttr  <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tblBaseWe,
  input  logic [31:0] tblBaseIn,
  input  logic        walkEn,
  input  logic        missValid,
  output logic        missReady,
  input  logic [31:0] missVa,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  output logic        resValid,
  output logic        resFault,
  output logic [1:0]  resSize,
  output logic [31:0] resAddr,
  output logic        resEndian,
  output logic [1:0]  resElemSize,
  output logic        resMixed
);

  walkStrobe_t strb;
  descKind_e   kindL1;
  pageSize_e   sizeOut;
  pageAttr_t   attrOut;

  pgwalk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .missValid(missValid), .walkEn(walkEn),
    .memRspValid(memRspValid), .kindL1(kindL1), .missReady(missReady), .strb(strb)
  );

  pgwalk_dp u_dp (
    .clk(clk), .rst_n(rst_n), .tblBaseWe(tblBaseWe), .tblBaseIn(tblBaseIn),
    .missVa(missVa), .memRspData(memRspData), .strb(strb), .kindL1(kindL1),
    .memReq(memReq), .memAddr(memAddr), .resValid(resValid), .resFault(resFault),
    .resSize(sizeOut), .resAddr(resAddr), .resAttr(attrOut)
  );

  assign resSize     = sizeOut;
  assign resEndian   = attrOut.endian;
  assign resElemSize = attrOut.elemSize;
  assign resMixed    = attrOut.mixed;

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        walkEn,
  input logic        missValid,
  input logic        missReady,
  input logic        memReq,
  input logic [31:0] memAddr,
  input logic        memRspValid,
  input logic        resValid,
  input logic        resFault,
  input logic [1:0]  resSize,
  input logic [31:0] resAddr
);

  // R10
  walk_off_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (missValid && missReady && !walkEn) |=> (resValid && resFault && !memReq));

  // R2
  l1_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (missValid && missReady && walkEn) |=> (memReq && !resValid));

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> (memAddr[1:0] == 2'b00));

  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> !missReady);

  // R11
  result_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> missReady);

  // R12
  result_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> $past(memRspValid || (missValid && missReady && !walkEn)));

  // R3
  section_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && !resFault && resSize == 2'd0) |-> (resAddr[19:0] == 20'd0));

  // R4
  super_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && !resFault && resSize == 2'd3) |-> (resAddr[23:0] == 24'd0));

  // R7
  small_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && !resFault && resSize == 2'd2) |-> (resAddr[11:0] == 12'd0));

  // R7
  large_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && !resFault && resSize == 2'd1) |-> (resAddr[15:0] == 16'd0));

endmodule

bind pgwalk_top pgwalk_chk u_chk (.*);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tblBaseWe = 1'b0;
  logic [31:0] tblBaseIn = '0;
  logic        walkEn = 1'b1;
  logic        missValid = 1'b0;
  logic        missReady;
  logic [31:0] missVa = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        resValid, resFault, resEndian, resMixed;
  logic [1:0]  resSize, resElemSize;
  logic [31:0] resAddr;

  typedef struct {
    bit        fault;
    bit [1:0]  size;
    bit [31:0] addr;
    bit        e;
    bit [1:0]  el;
    bit        m;
    int        due;
    string     tag;
  } exp_t;

  exp_t        q[$];
  int          cyc = 0;
  int          nChecks = 0;
  int          nFail = 0;
  logic [31:0] tbBase = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pgwalk_top u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic exp_t mk(bit f, bit [1:0] s, bit [31:0] a, bit e, bit [1:0] el, bit m, string tag);
    exp_t x;
    x.fault = f; x.size = s; x.addr = a; x.e = e; x.el = el; x.m = m; x.due = 0; x.tag = tag;
    return x;
  endfunction

  // monitor: pops the scoreboard whenever a result strobe is seen
  always @(negedge clk) begin
    if (rst_n && resValid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11 unexpected result", 32'd1, 32'd0);
      end else begin
        exp_t x;
        x = q.pop_front();
        chk(cyc == x.due, {x.tag, " R11 due cycle"}, cyc, x.due);
        chk({resFault, resSize, resEndian, resElemSize, resMixed} == {x.fault, x.size, x.e, x.el, x.m},
            {x.tag, " fields"}, {25'd0, resFault, resSize, resEndian, resElemSize, resMixed},
            {25'd0, x.fault, x.size, x.e, x.el, x.m});
        chk(resAddr == x.addr, {x.tag, " address"}, resAddr, x.addr);
      end
    end
  end

  task automatic setBase(input logic [31:0] v);
    @(negedge clk);
    tblBaseWe = 1'b1; tblBaseIn = v;
    @(negedge clk);
    tblBaseWe = 1'b0;
    tbBase = v;
  endtask

  task automatic walk(input logic [31:0] va, input bit en, input logic [31:0] d1,
                      input logic [31:0] d2, input exp_t e);
    logic [31:0] l1Addr, l2Addr;
    l1Addr = (tbBase & ~32'h7F) + {18'd0, va[31:20], 2'b00};
    l2Addr = {d1[31:10], va[19:12], 2'b00};
    @(negedge clk);
    chk(missReady == 1'b1, "R11 ready when idle", {31'd0, missReady}, 32'd1);
    missValid = 1'b1; missVa = va; walkEn = en;
    if (!en) begin
      e.due = cyc + 1;
      q.push_back(e);
    end
    @(negedge clk);
    missValid = 1'b0;
    if (!en) begin
      chk(memReq == 1'b0, "R10 no fetch when walking off", {31'd0, memReq}, 32'd0);
      walkEn = 1'b1;
      @(negedge clk);
      return;
    end
    chk(memReq == 1'b1, "R2 first fetch issued", {31'd0, memReq}, 32'd1);
    chk(memAddr == l1Addr, "R1 R2 first fetch address", memAddr, l1Addr);
    chk(missReady == 1'b0, "R11 busy during walk", {31'd0, missReady}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    memRspValid = 1'b1; memRspData = d1;
    if (d1[1:0] != 2'b01) begin
      e.due = cyc + 1;
      q.push_back(e);
    end
    @(negedge clk);
    memRspValid = 1'b0; memRspData = '0;
    if (d1[1:0] == 2'b01) begin
      chk(memReq == 1'b1, "R6 second fetch issued", {31'd0, memReq}, 32'd1);
      chk(memAddr == l2Addr, "R6 second fetch address", memAddr, l2Addr);
      @(negedge clk);
      memRspValid = 1'b1; memRspData = d2;
      e.due = cyc + 1;
      q.push_back(e);
      @(negedge clk);
      memRspValid = 1'b0; memRspData = '0;
    end
    chk(memReq == 1'b0, "R9 no further fetch after final descriptor", {31'd0, memReq}, 32'd0);
    @(negedge clk);
  endtask

  task automatic finish();
    chk(q.size() == 0, "R11 all results delivered", q.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog R11: actual hung expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(missReady == 1'b1, "R11 reset ready", {31'd0, missReady}, 32'd1);
    chk(resValid == 1'b0, "R11 reset no result", {31'd0, resValid}, 32'd0);
    chk(memReq == 1'b0, "R2 reset no fetch", {31'd0, memReq}, 32'd0);

    // R1: low seven bits of the base are dropped
    setBase(32'h8000_0FFF);

    // R3 R5: 1 MB section with attributes
    walk(32'h1234_5678, 1'b1, 32'hABC2_8802, '0,
         mk(1'b0, 2'd0, 32'hABC0_0000, 1'b1, 2'd2, 1'b1, "R3 R5"));
    // R4 R5: 16 MB supersection, bit 20 must not leak into base
    walk(32'hFFF0_0000, 1'b1, 32'h5A14_0402, '0,
         mk(1'b0, 2'd3, 32'h5A00_0000, 1'b0, 2'd1, 1'b0, "R4 R5"));
    // R6 R7 R8: coarse table then small page
    walk(32'h0003_5000, 1'b1, 32'h0040_0401, 32'h7777_7232,
         mk(1'b0, 2'd2, 32'h7777_7000, 1'b1, 2'd3, 1'b0, "R7 R8 small"));
    // R6 R7 R8: coarse table then large page
    walk(32'h8765_4321, 1'b1, 32'h1000_0C01, 32'h1234_5811,
         mk(1'b0, 2'd1, 32'h1234_0000, 1'b0, 2'd1, 1'b1, "R7 R8 large"));

    // R9: faults at both levels
    walk(32'h0BAD_0000, 1'b1, 32'h0000_0000, '0,
         mk(1'b1, 2'd0, 32'h0BAD_0000, 1'b0, 2'd0, 1'b0, "R9 L1 zero"));
    walk(32'h0BEE_F123, 1'b1, 32'hFFFF_FFFF, '0,
         mk(1'b1, 2'd0, 32'h0BEE_F123, 1'b0, 2'd0, 1'b0, "R9 L1 type3"));
    walk(32'h4444_4000, 1'b1, 32'h0020_0001, 32'h0000_0000,
         mk(1'b1, 2'd0, 32'h4444_4000, 1'b0, 2'd0, 1'b0, "R9 L2 zero"));
    walk(32'h5555_5000, 1'b1, 32'h0020_0001, 32'h0000_1003,
         mk(1'b1, 2'd0, 32'h5555_5000, 1'b0, 2'd0, 1'b0, "R9 L2 type3"));

    // R10: walking disabled
    walk(32'hCAFE_1000, 1'b0, '0, '0,
         mk(1'b1, 2'd0, 32'hCAFE_1000, 1'b0, 2'd0, 1'b0, "R10"));

    // R1: another base with low bits set, boundary VA index
    setBase(32'h0000_007F);
    walk(32'h0010_0000, 1'b1, 32'h0FF0_0002, '0,
         mk(1'b0, 2'd0, 32'h0FF0_0000, 1'b0, 2'd0, 1'b0, "R1 R3"));

    // R12: stray response while idle
    @(negedge clk);
    memRspValid = 1'b1; memRspData = 32'h1234_0002;
    @(negedge clk);
    memRspValid = 1'b0; memRspData = '0;
    chk(resValid == 1'b0, "R12 stray response ignored", {31'd0, resValid}, 32'd0);
    chk(memReq == 1'b0, "R12 stray response no fetch", {31'd0, memReq}, 32'd0);
    @(negedge clk);
    chk(resValid == 1'b0, "R12 still no result", {31'd0, resValid}, 32'd0);
    chk(missReady == 1'b1, "R12 still idle", {31'd0, missReady}, 32'd1);

    repeat (3) @(negedge clk);
    finish();
  end

endmodule